// File: doc/BRIEF.md
# Software-Managed Set-Associative Translation Buffer

This block holds a small set-associative table of virtual-to-physical page translations. Software fills and inspects the table only through three control registers: a page-address register that holds a virtual page number, a control register that holds a process identifier, a way selector, a read-command bit and a write-enable bit, and an access register that holds a frame number with permission flags. Software points the page-address register at a page. It then either issues a read command for one way, or sets write-enable and writes the access register. Each access-register write advances the way selector, so consecutive writes fill the ways of one set in order.

Alongside the register path, the block translates a virtual page number and process identifier combinationally. It returns hit, the winning way, the physical frame number and the five permission flags. The set is chosen by the low bits of the virtual page number. Entries whose page number lies in the reserved top quarter of the address space never translate, and reset fills every entry with that pattern.

Top module: `swtlb`

## Requirements
- R1: After reset all three register views read zero, every lookup misses, and a read command on set s returns page number 0xC0000 | s, process ID 0 and access word 0.
- R2: A page-address write keeps data bits [21:2] as the page number; the register view shows it in bits [21:2], with bits [1:0] and [31:22] reading zero.
- R3: The control register view has write-enable at bit 0, the read command at bit 1 (always reads 0), the way at bits [3:2] and the process ID at bits [15:8]. A write loads all three fields.
- R4: A control write with bit 1 set loads the selected way of the current set into the registers: page number into the page-address register, process ID into the control register, access word into the access register.
- R5: An access write with write-enable set stores {page number, process ID, access word} into the way given by the way field, in set = page number bits [3:0]. Without write-enable, an access write leaves the table unchanged.
- R6: Every access write advances the way field by one, wrapping from way 3 to way 0.
- R7: A lookup hits when an entry in the set has the same page number and either the same process ID or the global flag set. On a hit the frame number and flags appear in the same cycle. On a miss they read zero.
- R8: When several ways hit, the lowest-numbered way is reported.
- R9: A lookup whose page number has bits [19:18] equal to 2'b11 never hits, even against an entry written with that page number.
- R10: The access register keeps data bits [24:0]: frame number in [19:0] and flags read [20], write [21], execute [22], global [23], cached [24]. Bits [31:25] read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 page address, 1 control, 2 access, 3 none |
| cfg_wdata | input | 32 | Register write data |
| pta_q | output | 32 | Page-address register view |
| misc_q | output | 32 | Control register view |
| acc_q | output | 32 | Access register view |
| lk_vpn | input | 20 | Lookup virtual page number |
| lk_pid | input | 8 | Lookup process ID |
| lk_hit | output | 1 | Lookup hit |
| lk_way | output | 2 | Way that hit |
| lk_pfn | output | 20 | Translated frame number |
| lk_flags | output | 5 | Permission flags of the hit entry |

## Verification
The checker watches several rules on every cycle. It checks the zero bits of the register views, the read-command bit reading zero, the way step and wrap after each access write, and the capture of the access word. For lookups it checks that a reserved page number never hits, that a miss drives zero frame and flags, and that the reported way is the lowest among the ways that match. Only the bench scenarios can show that entries land in the right set and way, survive a write with write-enable clear, read back intact, and translate with or without a process-ID match through the global flag.

// File: rtl/swtlb_pkg.sv
package swtlb_pkg;
  localparam int VPN_W = 20;
  localparam int PID_W = 8;
  localparam int PFN_W = 20;
  localparam int FLG_W = 5;
  localparam int ACC_W = PFN_W + FLG_W;
  localparam int DATA_W = 32;

  // register select codes
  localparam logic [1:0] SEL_PTA  = 2'd0;
  localparam logic [1:0] SEL_MISC = 2'd1;
  localparam logic [1:0] SEL_ACC  = 2'd2;

  // control register field positions
  localparam int MISC_WE  = 0;
  localparam int MISC_RD  = 1;
  localparam int MISC_WAY = 2;
  localparam int MISC_PID = 8;

  // flag index inside the flag group
  localparam int FLG_GLOBAL = 3;

  typedef struct packed {
    logic [VPN_W-1:0] vpn;
    logic [PID_W-1:0] pid;
    logic [ACC_W-1:0] acc;
  } tlb_entry_t;

  function automatic logic [VPN_W-1:0] invalid_vpn(int unsigned set_idx);
    return {2'b11, {(VPN_W-2){1'b0}}} | VPN_W'(set_idx);
  endfunction

  function automatic logic is_reserved(logic [VPN_W-1:0] vpn);
    return vpn[VPN_W-1] & vpn[VPN_W-2];
  endfunction

  function automatic logic entry_hits(tlb_entry_t e, logic [VPN_W-1:0] vpn,
                                      logic [PID_W-1:0] pid);
    logic glob;
    glob = e.acc[PFN_W + FLG_GLOBAL];
    return (e.vpn == vpn) && !is_reserved(vpn) && ((e.pid == pid) || glob);
  endfunction
endpackage

// File: rtl/swtlb_store.sv
module swtlb_store
  import swtlb_pkg::*;
#(
  parameter int WAYS = 4,
  parameter int SETS = 16,
  localparam int WAY_W = $clog2(WAYS),
  localparam int SET_W = $clog2(SETS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [SET_W-1:0]      wr_set,
  input  logic [WAY_W-1:0]      wr_way,
  input  tlb_entry_t            wr_entry,
  input  logic [SET_W-1:0]      rd_set,
  input  logic [WAY_W-1:0]      rd_way,
  output tlb_entry_t            rd_entry,
  input  logic [SET_W-1:0]      lk_set,
  output tlb_entry_t [WAYS-1:0] lk_row
);
  tlb_entry_t mem [SETS][WAYS];

  for (genvar s = 0; s < SETS; s++) begin : g_set
    for (genvar w = 0; w < WAYS; w++) begin : g_way
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          mem[s][w] <= '{vpn: invalid_vpn(s), pid: '0, acc: '0};
        end else if (wr_en && (wr_set == SET_W'(s)) && (wr_way == WAY_W'(w))) begin
          mem[s][w] <= wr_entry;
        end
      end
    end
  end

  assign rd_entry = mem[rd_set][rd_way];

  for (genvar w = 0; w < WAYS; w++) begin : g_row
    assign lk_row[w] = mem[lk_set][w];
  end
endmodule

// File: rtl/swtlb_match.sv
module swtlb_match
  import swtlb_pkg::*;
#(
  parameter int WAYS = 4,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  tlb_entry_t [WAYS-1:0] row,
  input  logic [VPN_W-1:0]      vpn,
  input  logic [PID_W-1:0]      pid,
  output logic [WAYS-1:0]       hit_vec,
  output logic                  hit,
  output logic [WAY_W-1:0]      way,
  output logic [PFN_W-1:0]      pfn,
  output logic [FLG_W-1:0]      flags
);
  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hit_vec[w] = entry_hits(row[w], vpn, pid);
  end

  always_comb begin
    hit   = 1'b0;
    way   = '0;
    pfn   = '0;
    flags = '0;
    // scan downwards so the lowest way is the last to take effect
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (hit_vec[w]) begin
        hit   = 1'b1;
        way   = WAY_W'(w);
        pfn   = row[w].acc[PFN_W-1:0];
        flags = row[w].acc[ACC_W-1:PFN_W];
      end
    end
  end
endmodule

// File: rtl/swtlb_ctrl.sv
module swtlb_ctrl
  import swtlb_pkg::*;
#(
  parameter int WAYS = 4,
  parameter int SETS = 16,
  localparam int WAY_W = $clog2(WAYS),
  localparam int SET_W = $clog2(SETS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  tlb_entry_t        rd_entry,
  output logic [SET_W-1:0]  rd_set,
  output logic [WAY_W-1:0]  rd_way,
  output logic              wr_en,
  output logic [SET_W-1:0]  wr_set,
  output logic [WAY_W-1:0]  wr_way,
  output tlb_entry_t        wr_entry,
  output logic [VPN_W-1:0]  vpn_q,
  output logic [PID_W-1:0]  pid_q,
  output logic [WAY_W-1:0]  way_q,
  output logic              we_q,
  output logic [ACC_W-1:0]  acc_q
);
  logic wr_pta, wr_misc, wr_acc, rd_cmd;
  logic unused_hi;

  assign wr_pta  = cfg_we && (cfg_sel == SEL_PTA);
  assign wr_misc = cfg_we && (cfg_sel == SEL_MISC);
  assign wr_acc  = cfg_we && (cfg_sel == SEL_ACC);
  assign rd_cmd  = wr_misc && cfg_wdata[MISC_RD];
  assign unused_hi = ^cfg_wdata[DATA_W-1:ACC_W];

  assign rd_set   = vpn_q[SET_W-1:0];
  assign rd_way   = cfg_wdata[MISC_WAY +: WAY_W];
  assign wr_en    = wr_acc && we_q;
  assign wr_set   = vpn_q[SET_W-1:0];
  assign wr_way   = way_q;
  assign wr_entry = '{vpn: vpn_q, pid: pid_q, acc: cfg_wdata[ACC_W-1:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vpn_q <= '0;
      pid_q <= '0;
      way_q <= '0;
      we_q  <= 1'b0;
      acc_q <= '0;
    end else begin
      if (wr_pta) vpn_q <= cfg_wdata[2 +: VPN_W];
      if (wr_misc) begin
        way_q <= cfg_wdata[MISC_WAY +: WAY_W];
        we_q  <= cfg_wdata[MISC_WE];
        if (rd_cmd) begin
          vpn_q <= rd_entry.vpn;
          pid_q <= rd_entry.pid;
          acc_q <= rd_entry.acc;
        end else begin
          pid_q <= cfg_wdata[MISC_PID +: PID_W];
        end
      end
      if (wr_acc) begin
        acc_q <= cfg_wdata[ACC_W-1:0];
        way_q <= way_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/swtlb.sv
module swtlb
  import swtlb_pkg::*;
#(
  parameter int WAYS  = 4,
  parameter int PTR_W = 6,
  localparam int WAY_W = $clog2(WAYS),
  localparam int SET_W = PTR_W - WAY_W,
  localparam int SETS  = 1 << SET_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [DATA_W-1:0] pta_q,
  output logic [DATA_W-1:0] misc_q,
  output logic [DATA_W-1:0] acc_q,
  input  logic [VPN_W-1:0]  lk_vpn,
  input  logic [PID_W-1:0]  lk_pid,
  output logic              lk_hit,
  output logic [WAY_W-1:0]  lk_way,
  output logic [PFN_W-1:0]  lk_pfn,
  output logic [FLG_W-1:0]  lk_flags
);
  tlb_entry_t            rd_entry, wr_entry;
  tlb_entry_t [WAYS-1:0] lk_row;
  logic [SET_W-1:0]      rd_set, wr_set;
  logic [WAY_W-1:0]      rd_way, wr_way, way_r;
  logic                  wr_en, we_r;
  logic [VPN_W-1:0]      vpn_r;
  logic [PID_W-1:0]      pid_r;
  logic [ACC_W-1:0]      acc_r;
  logic [WAYS-1:0]       hit_vec;

  swtlb_ctrl #(.WAYS(WAYS), .SETS(SETS)) u_ctrl (
    .clk, .rst_n, .cfg_we, .cfg_sel, .cfg_wdata,
    .rd_entry, .rd_set, .rd_way,
    .wr_en, .wr_set, .wr_way, .wr_entry,
    .vpn_q(vpn_r), .pid_q(pid_r), .way_q(way_r), .we_q(we_r), .acc_q(acc_r)
  );

  swtlb_store #(.WAYS(WAYS), .SETS(SETS)) u_store (
    .clk, .rst_n,
    .wr_en, .wr_set, .wr_way, .wr_entry,
    .rd_set, .rd_way, .rd_entry,
    .lk_set(lk_vpn[SET_W-1:0]), .lk_row
  );

  swtlb_match #(.WAYS(WAYS)) u_match (
    .row(lk_row), .vpn(lk_vpn), .pid(lk_pid),
    .hit_vec, .hit(lk_hit), .way(lk_way), .pfn(lk_pfn), .flags(lk_flags)
  );

  always_comb begin
    pta_q  = '0;
    pta_q[2 +: VPN_W] = vpn_r;
    misc_q = '0;
    misc_q[MISC_WE] = we_r;
    misc_q[MISC_WAY +: WAY_W] = way_r;
    misc_q[MISC_PID +: PID_W] = pid_r;
    acc_q  = DATA_W'(acc_r);
  end
endmodule

// File: rtl/swtlb_chk.sv
module swtlb_chk
  import swtlb_pkg::*;
#(
  parameter int WAYS = 4,
  localparam int WAY_W = $clog2(WAYS)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_we,
  input logic [1:0]        cfg_sel,
  input logic [DATA_W-1:0] cfg_wdata,
  input logic [DATA_W-1:0] pta_q,
  input logic [DATA_W-1:0] misc_q,
  input logic [DATA_W-1:0] acc_q,
  input logic [VPN_W-1:0]  lk_vpn,
  input logic              lk_hit,
  input logic [WAY_W-1:0]  lk_way,
  input logic [PFN_W-1:0]  lk_pfn,
  input logic [FLG_W-1:0]  lk_flags,
  input logic [WAYS-1:0]   hit_vec
);
  logic acc_wr;
  assign acc_wr = cfg_we && (cfg_sel == SEL_ACC);

  assert_pta_zero_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pta_q[1:0] == 2'b00) && (pta_q[DATA_W-1:VPN_W+2] == '0));

  assert_rd_reads_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    misc_q[MISC_RD] == 1'b0);

  assert_way_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    acc_wr |=> misc_q[MISC_WAY +: WAY_W] == WAY_W'($past(misc_q[MISC_WAY +: WAY_W]) + 1'b1));

  assert_acc_capture_R10: assert property (@(posedge clk) disable iff (!rst_n)
    acc_wr |=> acc_q == DATA_W'($past(cfg_wdata[ACC_W-1:0])));

  assert_reserved_miss_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_vpn[VPN_W-1:VPN_W-2] == 2'b11) |-> !lk_hit);

  assert_miss_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> (lk_pfn == '0) && (lk_flags == '0));

  assert_lowest_way_R8: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> hit_vec[lk_way] && ((hit_vec & ((WAYS'(1) << lk_way) - WAYS'(1))) == '0));
endmodule

bind swtlb swtlb_chk u_chk (.*);

// File: tb/swtlb_bench.sv
module swtlb_bench;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [1:0]  op;    // 0 page addr, 1 control, 2 access, 3 lookup
    logic [31:0] data;  // write data or lookup page number
    logic [7:0]  pid;
    logic        hit;
    logic [24:0] expv;  // expected {flags, frame}
  } vec_t;

  localparam vec_t VECS [0:8] = '{
    '{2'd0, 32'h0004_8D14, 8'h00, 1'b0, 25'h0},        // page 0x12345, set 5
    '{2'd1, 32'h0000_2101, 8'h00, 1'b0, 25'h0},        // pid 0x21, way 0, write-enable
    '{2'd2, 32'h003A_BCDE, 8'h00, 1'b0, 25'h0},        // R|W, frame 0xABCDE
    '{2'd3, 32'h0001_2345, 8'h21, 1'b1, 25'h03A_BCDE}, // R7 pid match
    '{2'd3, 32'h0001_2345, 8'h22, 1'b0, 25'h0},        // R7 pid mismatch
    '{2'd0, 32'h0000_0054, 8'h00, 1'b0, 25'h0},        // page 0x00015, set 5
    '{2'd2, 32'h0080_0777, 8'h00, 1'b0, 25'h0},        // global, way 1
    '{2'd3, 32'h0000_0015, 8'h99, 1'b1, 25'h080_0777}, // R7 global hit
    '{2'd3, 32'h0000_0025, 8'h21, 1'b0, 25'h0}         // same set, other page
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = 2'd3;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] pta_q, misc_q, acc_q;
  logic [19:0] lk_vpn = '0;
  logic [7:0]  lk_pid = '0;
  logic        lk_hit;
  logic [1:0]  lk_way;
  logic [19:0] lk_pfn;
  logic [4:0]  lk_flags;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  swtlb u_swtlb (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] sel, logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0; cfg_sel = 2'd3;
  endtask

  task automatic look(string req, logic [19:0] v, logic [7:0] p, logic h,
                      logic [24:0] e);
    lk_vpn = v; lk_pid = p;
    #1;
    chk(req, {31'b0, lk_hit}, {31'b0, h});
    chk(req, {7'b0, lk_flags, lk_pfn}, h ? {7'b0, e} : 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 pta", pta_q, 32'h0);
    chk("R1 misc", misc_q, 32'h0);
    chk("R1 acc", acc_q, 32'h0);
    look("R1 lookup", 20'h00000, 8'h00, 1'b0, 25'h0);
    wr(2'd0, 32'h0000_000C);            // set 3
    wr(2'd1, 32'h0000_000A);            // R4 read way 2
    chk("R1 invalid vpn", pta_q, 32'h0030_000C);
    chk("R1 invalid acc", acc_q, 32'h0);

    // table walk
    for (int i = 0; i < 9; i++) begin
      if (VECS[i].op == 2'd3)
        look("R7 table", VECS[i].data[19:0], VECS[i].pid, VECS[i].hit, VECS[i].expv);
      else
        wr(VECS[i].op, VECS[i].data);
    end

    // R2 page-address masking
    wr(2'd0, 32'hFFFF_FFFF);
    chk("R2 pta mask", pta_q, 32'h003F_FFFC);
    // R3 control fields
    wr(2'd1, 32'h0000_AB0D);
    chk("R3 misc fields", misc_q, 32'h0000_AB0D);
    // R6 wrap from way 3
    wr(2'd2, 32'h0000_0000);
    chk("R6 way wrap", misc_q, 32'h0000_AB01);

    // R5 write without write-enable leaves entry alone
    wr(2'd1, 32'h0000_2100);
    wr(2'd0, 32'h0004_8D14);
    wr(2'd2, 32'h0000_0001);
    chk("R5 acc still loads", acc_q, 32'h0000_0001);
    chk("R6 step no-we", misc_q, 32'h0000_2104);
    look("R5 entry kept", 20'h12345, 8'h21, 1'b1, 25'h03A_BCDE);
    // R4 read back way 0 of set 5
    wr(2'd1, 32'h0000_0002);
    chk("R4 vpn", pta_q, 32'h0004_8D14);
    chk("R4 misc", misc_q, 32'h0000_2100);
    chk("R4 acc", acc_q, 32'h003A_BCDE);

    // R8 two hitting ways in set 7
    wr(2'd0, 32'h0000_001C);
    wr(2'd1, 32'h0000_0509);            // pid 5, way 2, we
    wr(2'd2, 32'h0030_0111);
    wr(2'd1, 32'h0000_0605);            // pid 6, way 1, we
    wr(2'd2, 32'h0090_0222);            // global
    look("R8 priority", 20'h00007, 8'h05, 1'b1, 25'h090_0222);
    chk("R8 way", {30'b0, lk_way}, 32'd1);
    look("R7 pid only", 20'h00007, 8'h07, 1'b1, 25'h090_0222);

    // R9 reserved page number never hits
    wr(2'd0, 32'h0030_0024);
    wr(2'd1, 32'h0000_0001);
    wr(2'd2, 32'h0080_0001);
    look("R9 reserved", 20'hC0009, 8'h00, 1'b0, 25'h0);

    // R10 access register width
    wr(2'd1, 32'h0000_0000);
    wr(2'd2, 32'hFFFF_FFFF);
    chk("R10 acc mask", acc_q, 32'h01FF_FFFF);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule